// File: doc/BRIEF.md
# Assertion Failure Bit Aggregator

This block sits between a set of in-circuit assertion checkers and a single streaming channel toward a host. Each checker gives a per-cycle strobe that says it evaluated its condition, plus the outcome. A failed evaluation sets one bit in a pending store. Every checker owns a fixed bit of a 32-bit word. When there are more than 32 checkers, the checkers are spread across several lanes of 32 bits each, and the outgoing word carries a lane index beside the data. The channel stays silent while every evaluated condition holds. When the host side applies back-pressure, failures keep accumulating and none of them is dropped.

The block also produces a halt output that freezes the monitored application. In the default policy, halt rises once the first failure word has been handed over, and it stays high until reset. When the continue input is high, halt is never raised and reporting goes on without limit. A build-time parameter removes all reporting logic. In that build the channel never carries a word and halt never rises.

Top module: `assert_fail_aggregator`

## Requirements
- R1: Checker number k maps to lane k/32 and bit k%32 of the data word. The lane number appears on `out_lane`. Bits of the last lane that no checker owns are always 0.
- R2: Checkers that fail in the same cycle all appear together in one word, provided they share a lane.
- R3: A checker has failed only when its strobe is 1 and its pass input is 0 in the same cycle. While no checker has failed and nothing is pending, `out_valid` stays 0.
- R4: A failure in cycle t causes `out_valid` to be 1 in cycle t+1.
- R5: While `out_ready` is 0, new failures are OR-merged into the pending bits. Pending bits are kept until a handshake accepts them.
- R6: A handshake (`out_valid` and `out_ready` both 1) clears only the bits of the accepted word. A failure that arrives in the same cycle as the accepting handshake is kept, even on a bit that was just accepted.
- R7: When several lanes hold pending bits, the lane with the lowest index is presented first.
- R8: With `keep_going` = 0, halt rises in the cycle after the first accepting handshake. Once high, halt stays high until reset, whatever `keep_going` does afterwards, and reporting carries on.
- R9: With `keep_going` = 1, accepted words never raise halt.
- R10: With REPORT_EN = 0, `out_valid` and `halt` stay 0 whatever the checkers report.
- R11: After a synchronous active-low reset, `out_valid` = 0, `halt` = 0, and no bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid | input | NUM_CHECKS | Per-checker strobe: condition evaluated this cycle |
| chk_pass | input | NUM_CHECKS | Per-checker outcome, 1 = condition held |
| keep_going | input | 1 | 1 = continue after failures, 0 = halt after the first report |
| out_valid | output | 1 | A failure word is offered |
| out_ready | input | 1 | Host side accepts the offered word |
| out_lane | output | LANE_W | Lane index of the offered word |
| out_data | output | 32 | One bit per checker of that lane, 1 = failed |
| halt | output | 1 | Stop request toward the monitored application |

## Verification
The hardest case to reach is the cycle in which a handshake accepts a word while new failures land on the same lane, some of them on bits that are being cleared in that very cycle. The stimulus first builds up pending bits under back-pressure and then releases `out_ready` exactly while the same checker fails again. A second such case presents two lanes at once, so that the lower lane drains while the upper one keeps gathering bits. A long phase of random strobes and random back-pressure, compared every cycle against a behavioural model, covers the mixed cases.

// File: rtl/aggr_pkg.sv
// Package: shared constants and helpers for the failure aggregator.
// Assumes a fixed 32-bit channel word; lane count derives from checker count.
package aggr_pkg;
    localparam int WORD_W = 32;

    // Number of 32-bit lanes needed to hold n checker bits.
    function automatic int lanes_for(input int n);
        return (n + WORD_W - 1) / WORD_W;
    endfunction

    // Width of a lane index; at least one bit.
    function automatic int lane_idx_w(input int lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction
endpackage

// File: rtl/aggr_lane.sv
// Module: aggr_lane
// Holds the pending failure bits of one 32-bit lane. Bits listed in clr_i
// are dropped, then new failures are OR-merged in, so a bit that fails again
// in its clearing cycle survives.
// Assumes clr_i only names bits that are currently pending.
module aggr_lane #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fail_i,
    input  logic [WORD_W-1:0] clr_i,
    output logic [WORD_W-1:0] pend_o
);
    logic [WORD_W-1:0] pend_q;

    // Pending store: clear accepted bits, then merge new failures.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | fail_i;
    end

    assign pend_o = pend_q;

    // New failures are captured in the following cycle.
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_i != '0) |=> ((pend_q & $past(fail_i)) == $past(fail_i)));

    // Bits not accepted are never lost.
    assert_keep_unaccepted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~clr_i) != '0) |=>
        ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));

    // Accepted bits with no fresh failure are gone afterwards.
    assert_clear_accepted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~fail_i) != '0) |=> ((pend_q & $past(clr_i & ~fail_i)) == '0));
endmodule

// File: rtl/aggr_pick.sv
// Module: aggr_pick
// Chooses the lowest-numbered lane that holds pending bits and presents it.
// Assumes pend_i is the flat concatenation of all lanes, lane 0 at the LSBs.
module aggr_pick #(
    parameter int LANES  = 2,
    parameter int WORD_W = 32,
    parameter int LANE_W = 1
) (
    input  logic [LANES*WORD_W-1:0] pend_i,
    output logic                    any_o,
    output logic [LANE_W-1:0]       lane_o,
    output logic [WORD_W-1:0]       word_o
);
    // Priority scan: the last match walking downward is the lowest lane.
    always_comb begin
        any_o  = 1'b0;
        lane_o = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend_i[i*WORD_W +: WORD_W] != '0) begin
                any_o  = 1'b1;
                lane_o = LANE_W'(i);
            end
        end
    end

    // Word of the chosen lane.
    always_comb begin
        word_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_o == LANE_W'(i)) word_o = pend_i[i*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/aggr_halt.sv
// Module: aggr_halt
// Sticky stop request: set by a handshake in abort policy, cleared only by reset.
// Assumes fire_i already combines handshake and policy.
module aggr_halt (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic halt_o
);
    logic halt_q;

    // Halt flag: set once, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      halt_q <= 1'b0;
        else if (fire_i) halt_q <= 1'b1;
    end

    assign halt_o = halt_q;

    // Once raised, halt never drops without reset.
    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |=> halt_q);

    // Halt only rises right after an abort-policy handshake.
    assert_halt_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_q && !fire_i) |=> !halt_q);
endmodule

// File: rtl/assert_fail_aggregator.sv
// Module: assert_fail_aggregator
// Gathers failures from NUM_CHECKS assertion checkers into per-lane pending
// bits and streams them out one 32-bit lane word at a time, lowest lane
// first, with a valid/ready handshake. Drives a sticky halt in abort policy.
// Assumes checker outcomes are synchronous to clk; REPORT_EN = 0 removes reporting.
module assert_fail_aggregator
    import aggr_pkg::*;
#(
    parameter int NUM_CHECKS = 40,
    parameter bit REPORT_EN  = 1'b1,
    localparam int LANES  = lanes_for(NUM_CHECKS),
    localparam int LANE_W = lane_idx_w(LANES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CHECKS-1:0] chk_valid,
    input  logic [NUM_CHECKS-1:0] chk_pass,
    input  logic                  keep_going,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [LANE_W-1:0]     out_lane,
    output logic [WORD_W-1:0]     out_data,
    output logic                  halt
);
    localparam int FLAT_W = LANES * WORD_W;

    logic [FLAT_W-1:0] fail_flat;
    logic [FLAT_W-1:0] pend_flat;
    logic              accept;

    // Failure vector padded to whole lanes; unowned bits stay zero.
    always_comb begin
        fail_flat = '0;
        fail_flat[NUM_CHECKS-1:0] = chk_valid & ~chk_pass;
    end

    assign accept = out_valid & out_ready;

    generate
        if (REPORT_EN) begin : g_on
            for (genvar g = 0; g < LANES; g++) begin : g_lane
                logic [WORD_W-1:0] clr;
                // Clear mask: the offered word, only for the selected lane on a handshake.
                assign clr = (accept && (out_lane == LANE_W'(g))) ? out_data : '0;
                aggr_lane #(.WORD_W(WORD_W)) u_lane (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .fail_i (fail_flat[g*WORD_W +: WORD_W]),
                    .clr_i  (clr),
                    .pend_o (pend_flat[g*WORD_W +: WORD_W])
                );
            end

            // Any failure is offered on the next cycle.
            assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (fail_flat != '0) |=> out_valid);
        end else begin : g_off
            // Reporting removed: nothing is ever pending.
            assign pend_flat = fail_flat & {FLAT_W{1'b0}};
        end
    endgenerate

    aggr_pick #(.LANES(LANES), .WORD_W(WORD_W), .LANE_W(LANE_W)) u_pick (
        .pend_i (pend_flat),
        .any_o  (out_valid),
        .lane_o (out_lane),
        .word_o (out_data)
    );

    aggr_halt u_halt (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (accept & ~keep_going),
        .halt_o (halt)
    );

    // Silence while nothing failed and nothing is pending.
    assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && fail_flat == '0) |=> !out_valid);

    // An offered word always names at least one failure.
    assert_nonempty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data != '0));
endmodule

// File: tb/sim_assert_fail_aggregator.sv
module sim_assert_fail_aggregator;
    localparam int N = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  chk_valid = '0;
    logic [N-1:0]  chk_pass = '0;
    logic          keep_going = 1'b1;
    logic          out_ready = 1'b0;
    logic          out_valid, halt;
    logic [0:0]    out_lane;
    logic [31:0]   out_data;
    logic          off_valid, off_halt;
    logic [0:0]    off_lane;
    logic [31:0]   off_data;

    int n_vec = 0;
    int n_bad = 0;
    string tag = "R11";

    // Behavioural model state.
    logic [31:0] m_pend [2];
    logic        m_halt;

    always #5 clk = ~clk;

    assert_fail_aggregator #(.NUM_CHECKS(N), .REPORT_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_pass(chk_pass),
        .keep_going(keep_going), .out_valid(out_valid), .out_ready(out_ready),
        .out_lane(out_lane), .out_data(out_data), .halt(halt));

    assert_fail_aggregator #(.NUM_CHECKS(N), .REPORT_EN(1'b0)) u_off (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_pass(chk_pass),
        .keep_going(keep_going), .out_valid(off_valid), .out_ready(out_ready),
        .out_lane(off_lane), .out_data(off_data), .halt(off_halt));

    function automatic logic [N-1:0] bit_of(input int k);
        logic [N-1:0] v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare all outputs against the model.
    task automatic compare();
        logic       ev;
        logic [0:0] el;
        ev = (m_pend[0] != 0) || (m_pend[1] != 0);
        el = (m_pend[0] != 0) ? 1'b0 : 1'b1;
        check(tag, "out_valid", {31'b0, out_valid}, {31'b0, ev});
        if (ev) begin
            check(tag, "out_lane", {31'b0, out_lane}, {31'b0, el});
            check(tag, "out_data", out_data, m_pend[el]);
        end
        check(tag, "halt", {31'b0, halt}, {31'b0, m_halt});
        check("R10", "off_valid", {31'b0, off_valid}, 32'd0);
        check("R10", "off_halt", {31'b0, off_halt}, 32'd0);
    endtask

    // One cycle: drive at negedge, compare, step model across the posedge.
    task automatic step(input logic [N-1:0] v, input logic [N-1:0] p,
                        input logic rdy, input logic kg);
        logic [N-1:0] f;
        logic         ev;
        logic         el;
        chk_valid = v; chk_pass = p; out_ready = rdy; keep_going = kg;
        #1;
        compare();
        f  = v & ~p;
        ev = (m_pend[0] != 0) || (m_pend[1] != 0);
        el = (m_pend[0] != 0) ? 1'b0 : 1'b1;
        @(posedge clk);
        if (ev && rdy) begin
            m_pend[el] = 32'h0;
            if (!kg) m_halt = 1'b1;
        end
        m_pend[0] = m_pend[0] | f[31:0];
        m_pend[1] = m_pend[1] | {24'b0, f[39:32]};
        @(negedge clk);
    endtask

    task automatic do_reset();
        tag = "R11";
        rst_n = 1'b0;
        chk_valid = '0; chk_pass = '0; out_ready = 1'b0;
        @(negedge clk); @(negedge clk);
        m_pend[0] = 0; m_pend[1] = 0; m_halt = 1'b0;
        compare();
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        m_pend[0] = 0; m_pend[1] = 0; m_halt = 1'b0;
        do_reset();

        // R3: passes, and fails without strobe, never produce traffic.
        tag = "R3";
        step('0, '0, 1, 1);
        step({N{1'b1}}, {N{1'b1}}, 1, 1);
        step('0, {N{1'b0}}, 1, 1);
        step(40'h00_FFFF_0000, 40'hFF_FFFF_FFFF, 1, 1);
        step('0, '0, 1, 1);

        // R1 / R4: single failures on lane 0 and lane 1.
        tag = "R4";
        step(bit_of(5), '0, 1, 1);
        tag = "R1";
        step('0, '0, 1, 1);
        step(bit_of(37), '0, 1, 1);
        step('0, '0, 1, 1);
        step(bit_of(39), '0, 1, 1);
        step('0, '0, 1, 1);

        // R2: simultaneous failures share one word.
        tag = "R2";
        step(bit_of(2) | bit_of(9) | bit_of(31), bit_of(9) & '0, 1, 1);
        step('0, '0, 1, 1);

        // R5: accumulate under back-pressure, then drain.
        tag = "R5";
        step(bit_of(3), '0, 0, 1);
        step(bit_of(7), '0, 0, 1);
        step(bit_of(3), '0, 0, 1);
        step('0, '0, 0, 1);
        step('0, '0, 1, 1);
        step('0, '0, 1, 1);

        // R6: new failure on an accepted bit in the accept cycle survives.
        tag = "R6";
        step(bit_of(3), '0, 0, 1);
        step(bit_of(3) | bit_of(4), '0, 1, 1);
        step('0, '0, 0, 1);
        step('0, '0, 1, 1);
        step('0, '0, 1, 1);

        // R7: two lanes pending, lower lane first while upper keeps gathering.
        tag = "R7";
        step(bit_of(1) | bit_of(33), '0, 0, 1);
        step('0, '0, 1, 1);
        step(bit_of(34), '0, 0, 1);
        step(bit_of(0), '0, 1, 1);
        step('0, '0, 1, 1);
        step('0, '0, 1, 1);
        step('0, '0, 1, 1);

        // R9: continue policy never halts.
        tag = "R9";
        for (int i = 0; i < 12; i++) step(bit_of(i * 3), '0, 1, 1);
        step('0, '0, 1, 1);

        // R8: abort policy, halt after first accepted word, sticky.
        do_reset();
        tag = "R8";
        step(bit_of(10), '0, 0, 0);
        step('0, '0, 0, 0);
        step('0, '0, 0, 0);
        step('0, '0, 1, 0);
        step(bit_of(36), '0, 1, 1);
        step('0, '0, 1, 1);
        step('0, '0, 1, 1);

        // Mixed random traffic against the model.
        do_reset();
        tag = "R5";
        for (int i = 0; i < 400; i++) begin
            logic [N-1:0] v, p;
            v = {$urandom, $urandom} & {$urandom, $urandom};
            p = ~({$urandom, $urandom} & {$urandom, $urandom});
            step(v, p, 1'($urandom % 3 != 0), 1'($urandom % 8 != 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule